// File: doc/BRIEF.md
# Byte-Wide SPI Slave Peripheral

This block is an SPI slave that sits on a small local register bus, in the way a microcontroller peripheral does. An external master selects it with an active-low select line and clocks it with SCK. In one transfer, one byte moves in each direction, most significant bit first, in SPI mode 0. All external pins pass through two-flop synchronisers into the system clock domain. The shifter acts on SCK edges that are detected there, so no logic runs on the serial clock.

The local side loads the next byte to send into a transmit holding register. It can do this at any time, and also while the slave is deselected. Loading into the shift register happens only when select falls, so SCK pulses seen while deselected shift nothing out. A completed byte goes into a receive buffer that is separate from the shift register. The local side can therefore queue its next reply before it reads what just arrived.

Each completed byte sets a completion flag, and the flag can raise an interrupt. Software clears the flag in two steps: it reads the status register, then accesses the data register. The MISO output enable is held low while the slave is not selected. If select rises before eight bits have arrived, the partial byte is dropped.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, reads of every register return 0, `irq` is 0 and `miso_oe` is 0.
- R2: While `ss_n` is high, `miso_oe` is 0. SCK activity during that time changes neither the receive buffer nor the completion flag. Writes to the data register (address 0) are accepted in that state.
- R3: MOSI is sampled on each rising SCK edge, MSB first. After the eighth rising edge of a selection, the assembled byte is placed in the receive buffer, which is read at address 0.
- R4: When `ss_n` falls, the transmit holding byte is loaded. Its MSB is on `miso_o` with `miso_oe` high before the first SCK edge. Each following bit appears after a falling SCK edge.
- R5: The completion flag is status bit 0 at address 2. It becomes 1 once the eighth bit of a selection has been received.
- R6: `irq` is high exactly when the completion flag is set and control bit 0 (interrupt enable, address 1, readable) is 1. It follows them by one clock.
- R7: The flag clears only when a data-register access (read or write) follows a status read that saw the flag set. A data access without that prior status read leaves the flag set.
- R8: Writing the next transmit byte before reading the received one leaves the receive buffer unchanged. The buffer changes only when another full byte completes.
- R9: If `ss_n` rises before the eighth bit, the partial byte is discarded: the flag stays clear and the receive buffer keeps its old value.
- R10: The transmit holding register keeps its value across transfers, so the same byte is sent again when the local side writes nothing new.
- R11: Once eight bits have been received in a selection, further SCK edges in that selection are ignored: the receive buffer still holds the first eight bits.
- R12: Read data appears on `bus_rdata` one clock after the read access. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Local bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 control, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |

## Verification
The assertions assume that SCK holds each level for more than the synchroniser depth in system clocks. They also assume that MOSI is steady around each rising edge and that select changes only while SCK is low. Under those conditions every edge is seen exactly once in the synchronised domain. The stimulus uses eight-cycle SCK half periods and changes MOSI four cycles before each rising edge. It moves select only with SCK low and with at least eight idle cycles on each side. A sweep over all 256 received values, each paired with a different preloaded reply, covers the data path, and directed cases cover the abort, overrun-clock, deselected-clock and flag-clearing orderings.

// File: rtl/spis_pkg.sv
package spis_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [1:0] addr);
    case (addr)
      2'd0:    return REG_DATA;
      2'd1:    return REG_CTRL;
      2'd2:    return REG_STAT;
      default: return REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int                WIDTH     = 3,
  parameter int                STAGES    = 2,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= RESET_VAL;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RESET_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spis_shifter.sv
module spis_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              ss_n_s,
  input  logic [DATA_W-1:0] tx_load,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_word,
  output logic              miso_bit,
  output logic              miso_en
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              sck_q;
  logic              ss_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic              miso_en_q;

  logic sck_rise, sck_fall, ss_fall, selected, in_byte;

  always_comb begin
    sck_rise = sck_s & ~sck_q;
    sck_fall = ~sck_s & sck_q;
    ss_fall  = ~ss_n_s & ss_q;
    selected = ~ss_n_s;
    in_byte  = selected & (bit_cnt < CNT_W'(DATA_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      ss_q      <= 1'b1;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      miso_en_q <= 1'b0;
    end else begin
      sck_q     <= sck_s;
      ss_q      <= ss_n_s;
      miso_en_q <= selected;
      if (ss_fall) begin
        bit_cnt <= '0;
        tx_sr   <= tx_load;
      end else if (in_byte) begin
        if (sck_rise) begin
          rx_sr   <= {rx_sr[DATA_W-3:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall && bit_cnt != '0) begin
          tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rx_done  = in_byte & ~ss_fall & sck_rise & (bit_cnt == CNT_W'(DATA_W - 1));
  assign rx_word  = {rx_sr, mosi_s};
  assign miso_bit = tx_sr[DATA_W-1];
  assign miso_en  = miso_en_q;

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst) bit_cnt <= CNT_W'(DATA_W)); // R11
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst) ss_n_s |=> ($stable(tx_sr) && $stable(rx_sr))); // R2

endmodule

// File: rtl/spis_regs.sv
module spis_regs
  import spis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_word,
  output logic [DATA_W-1:0] tx_hold
);

  reg_sel_e          sel;
  logic              data_acc, stat_rd, data_wr, ctrl_wr, rd_acc;
  logic [DATA_W-1:0] tx_hold_q, rx_buf_q, rdata_q, rd_mux;
  logic              ie_q, flag_q, armed_q, irq_q;

  always_comb begin
    sel      = decode_addr(bus_addr);
    data_acc = bus_en & (sel == REG_DATA);
    data_wr  = data_acc & bus_we;
    ctrl_wr  = bus_en & bus_we & (sel == REG_CTRL);
    stat_rd  = bus_en & ~bus_we & (sel == REG_STAT);
    rd_acc   = bus_en & ~bus_we;
    case (sel)
      REG_DATA: rd_mux = rx_buf_q;
      REG_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, ie_q};
      REG_STAT: rd_mux = {{(DATA_W-1){1'b0}}, flag_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold_q <= '0;
      rx_buf_q  <= '0;
      rdata_q   <= '0;
      ie_q      <= 1'b0;
      flag_q    <= 1'b0;
      armed_q   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (data_wr) tx_hold_q <= bus_wdata;
      if (ctrl_wr) ie_q      <= bus_wdata[0];
      if (rx_done) rx_buf_q  <= rx_word;
      if (rd_acc)  rdata_q   <= rd_mux;

      if (rx_done)                  flag_q <= 1'b1;
      else if (armed_q && data_acc) flag_q <= 1'b0;

      if (rx_done)                  armed_q <= 1'b0;
      else if (stat_rd && flag_q)   armed_q <= 1'b1;
      else if (data_acc)            armed_q <= 1'b0;

      irq_q <= flag_q & ie_q;
    end
  end

  assign tx_hold   = tx_hold_q;
  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (rst) rx_done |=> flag_q); // R5
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst) $fell(flag_q) |-> ($past(armed_q) && $past(data_acc))); // R7
  AST_RXBUF_HELD: assert property (@(posedge clk) disable iff (rst) !rx_done |=> $stable(rx_buf_q)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) !$past(flag_q) |-> !irq_q); // R6

endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ss_n,
  output logic              miso_o,
  output logic              miso_oe
);

  logic [2:0]        pins_s;
  logic              rx_done;
  logic [DATA_W-1:0] rx_word, tx_hold;

  spis_sync #(
    .WIDTH     (3),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ss_n, sck, mosi}),
    .q   (pins_s)
  );

  spis_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (pins_s[1]),
    .mosi_s   (pins_s[0]),
    .ss_n_s   (pins_s[2]),
    .tx_load  (tx_hold),
    .rx_done  (rx_done),
    .rx_word  (rx_word),
    .miso_bit (miso_o),
    .miso_en  (miso_oe)
  );

  spis_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .rx_done   (rx_done),
    .rx_word   (rx_word),
    .tx_hold   (tx_hold)
  );

  AST_MISO_HIZ: assert property (@(posedge clk) disable iff (rst) ($past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3)) |-> !miso_oe); // R2

endmodule

// File: tb/spi_byte_slave_bench.sv
module spi_byte_slave_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, miso_o, miso_oe;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_byte_slave u_spi_byte_slave (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic spi_xfer(input logic [7:0] mo, input int nbits, input logic [7:0] exp_tx,
                          input bit chk_tx, output logic [7:0] got);
    logic [7:0] g;
    g = 8'h00;
    @(negedge clk);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    if (chk_tx) begin
      check(miso_oe === 1'b1, "R4 miso enabled before first edge", int'(miso_oe), 1);
      check(miso_o === exp_tx[7], "R4 msb before first edge", int'(miso_o), int'(exp_tx[7]));
    end
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? mo[7-i] : 1'b1;
      repeat (4) @(negedge clk);
      if (i < 8) g[7-i] = miso_o;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
    got = g;
  endtask

  function automatic logic [7:0] tx_pat(input int v);
    return 8'((v * 37 + 11) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got, last_rx, cur_tx;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state, R12 unused address
    check(irq === 1'b0, "R1 irq after reset", int'(irq), 0);
    check(miso_oe === 1'b0, "R1 miso_oe after reset", int'(miso_oe), 0);
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), d);
      check(d === 8'h00, (a == 3) ? "R12 address 3 reads zero" : "R1 register reset value", int'(d), 0);
    end

    // R2: deselected SCK activity, preload while deselected
    bus_write(2'd0, 8'hC3);
    for (int i = 0; i < 8; i++) begin
      mosi = i[0];
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (8) @(negedge clk);
      check(miso_oe === 1'b0, "R2 miso hi-z while deselected", int'(miso_oe), 0);
      sck = 1'b0;
      repeat (4) @(negedge clk);
    end
    bus_read(2'd2, d);
    check(d === 8'h00, "R2 no flag from deselected clocks", int'(d), 0);
    bus_read(2'd0, d);
    check(d === 8'h00, "R2 rx buffer untouched while deselected", int'(d), 0);
    spi_xfer(8'h96, 8, 8'hC3, 1'b1, got);
    check(got === 8'hC3, "R2 preloaded byte sent intact", int'(got), 8'hC3);

    // R7: data access without status read keeps flag
    bus_read(2'd0, d);
    check(d === 8'h96, "R3 received byte", int'(d), 8'h96);
    bus_read(2'd2, d);
    check(d === 8'h01, "R7 flag kept after bare data read", int'(d), 1);
    bus_read(2'd0, d);
    bus_read(2'd2, d);
    check(d === 8'h00, "R7 flag cleared by status then data read", int'(d), 0);

    // R10: resend without new write
    spi_xfer(8'h3C, 8, 8'hC3, 1'b1, got);
    check(got === 8'hC3, "R10 same byte sent again", int'(got), 8'hC3);

    // R6: interrupt masked, then enabled
    repeat (3) @(negedge clk);
    check(irq === 1'b0, "R6 irq masked with enable clear", int'(irq), 0);
    bus_write(2'd1, 8'h01);
    bus_read(2'd1, d);
    check(d === 8'h01, "R6 control readback", int'(d), 1);
    repeat (2) @(negedge clk);
    check(irq === 1'b1, "R6 irq with flag and enable", int'(irq), 1);
    bus_read(2'd2, d);
    bus_write(2'd0, 8'h5A);   // R7 write as clearing access
    repeat (2) @(negedge clk);
    check(irq === 1'b0, "R6 irq drops after clear", int'(irq), 0);
    bus_read(2'd2, d);
    check(d === 8'h00, "R7 flag cleared by status then data write", int'(d), 0);
    bus_read(2'd0, d);
    check(d === 8'h3C, "R8 rx kept after tx write", int'(d), 8'h3C);
    bus_write(2'd1, 8'h00);

    // R9: aborted byte
    spi_xfer(8'hFF, 5, 8'h5A, 1'b0, got);
    bus_read(2'd2, d);
    check(d === 8'h00, "R9 no flag after abort", int'(d), 0);
    bus_read(2'd0, d);
    check(d === 8'h3C, "R9 rx buffer kept after abort", int'(d), 8'h3C);

    // R11: extra clocks in one selection
    spi_xfer(8'hA1, 11, 8'h5A, 1'b1, got);
    check(got === 8'h5A, "R4 tx after abort reload", int'(got), 8'h5A);
    bus_read(2'd2, d);
    check(d === 8'h01, "R5 flag after full byte", int'(d), 1);
    bus_read(2'd0, d);
    check(d === 8'hA1, "R11 first eight bits kept", int'(d), 8'hA1);

    // Sweep: all received values, varying preload (R3 R4 R5 R7 R8)
    cur_tx = tx_pat(0);
    bus_write(2'd0, cur_tx);
    last_rx = 8'hA1;
    for (int v = 0; v < 256; v++) begin
      spi_xfer(8'(v), 8, cur_tx, 1'b1, got);
      check(got === cur_tx, "R4 sweep miso byte", int'(got), int'(cur_tx));
      bus_read(2'd2, d);
      check(d === 8'h01, "R5 sweep flag set", int'(d), 1);
      cur_tx = tx_pat(v + 1);
      bus_write(2'd0, cur_tx);
      bus_read(2'd0, d);
      check(d === 8'(v), "R8 sweep rx after next tx write", int'(d), v);
      bus_read(2'd2, d);
      check(d === 8'h00, "R7 sweep flag cleared", int'(d), 0);
      last_rx = 8'(v);
    end
    bus_read(2'd0, d);
    check(d === last_rx, "R3 rx buffer holds last byte", int'(d), int'(last_rx));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule